// File: doc/BRIEF.md
# Neighbour Compare and Arrow-Direction Unit

This unit classifies one pixel of an image against its four direct neighbours (west, north, east, south) for a steepest-descent labelling pass. It receives the centre value, the four neighbour values with a per-neighbour validity bit, the status code of each neighbour and a mode bit that tells whether the pixel arrives from the fresh-pixel scan or from a plateau queue. From these it finds the lowest neighbour and where it lies, marks which neighbours share the centre's value, raises a plateau flag or an inner flag according to the mode, and produces the 3-bit arrow code that goes to arrow memory.

A neighbour that lies outside the image is presented with its validity bit low and behaves as an infinitely high value: it never becomes the minimum, never counts as equal and never prevents the centre from being an inner pixel. For an inner plateau pixel the arrow does not follow the minimum; it points to an equal-valued neighbour that has already been labelled from the second queue (status code 5), picking the first such neighbour in west, north, east, south order. All logic is combinational; a parameter selects whether the results are registered (default) or passed straight through.

Top module: `nbr_arrow_unit`

## Requirements
- R1: `min_val` is the value of the smallest valid neighbour; when no neighbour is valid it is all ones.
- R2: `min_dir` gives the position of the smallest valid neighbour as 1 = west, 2 = north, 3 = east, 4 = south, and 0 when no neighbour is valid.
- R3: When two or more valid neighbours share the smallest value, `min_dir` names the earliest of them in the order west, north, east, south.
- R4: `eq_flags` bit 0 (west), bit 1 (north), bit 2 (east) and bit 3 (south) is 1 exactly when that neighbour is valid and equal to the centre, in either mode.
- R5: `plat_flag` is 1 exactly when `scan_mode` is 1 and at least one bit of `eq_flags` is 1; it is 0 whenever `scan_mode` is 0.
- R6: `inner_flag` is 1 exactly when `scan_mode` is 0 and the centre is less than or equal to every valid neighbour (also when none is valid); it is 0 whenever `scan_mode` is 1.
- R7: When `inner_flag` is 0, `arrow_code` equals `min_dir` if the smallest valid neighbour is strictly lower than the centre, and 0 otherwise.
- R8: When `inner_flag` is 1, `arrow_code` names the first neighbour in west, north, east, south order whose `eq_flags` bit is 1 and whose 3-bit status field holds 5; it is 0 if no neighbour qualifies.
- R9: A neighbour with its validity bit at 0 has no effect on any output, whatever its value and status.
- R10: With `REG_OUT` = 1 every output reflects the inputs sampled at the previous rising clock edge, and while `rst` is 1 all outputs are 0 at the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| scan_mode | input | 1 | 1 = fresh-pixel scan, 0 = plateau-queue processing |
| ctr_val | input | PW | Centre pixel value |
| nbr_val | input | 4*PW | Neighbour values, slot i at bits [i*PW +: PW], i = 0 W, 1 N, 2 E, 3 S |
| nbr_ok | input | 4 | Neighbour validity, same slot order |
| nbr_stat | input | 4*SW | Neighbour status codes, slot i at bits [i*SW +: SW] |
| min_val | output | PW | Smallest valid neighbour value |
| min_dir | output | 3 | Position code of the smallest valid neighbour |
| eq_flags | output | 4 | Per-neighbour equal-to-centre flags |
| plat_flag | output | 1 | Plateau pixel found during scan |
| inner_flag | output | 1 | Inner plateau pixel during queue processing |
| arrow_code | output | 3 | Arrow to write: 0 none, 1 W, 2 N, 3 E, 4 S |

## Verification
The unit holds no state apart from the output register, so any fault shows at the ports in the cycle after the offending inputs are sampled: a wrong comparator branch produces a wrong `min_dir` or `min_val`, a faulty tie rule moves the arrow to a later neighbour, and a wrong mode decode raises `plat_flag` or `inner_flag` in the wrong mode. The stimulus therefore concentrates on equal values (small value ranges with random validity and status) so that ties, plateaus, invalid-but-equal neighbours and inner pixels with several labelled candidates occur on many cycles. A stale or unreset register shows as a mismatch on the first cycle after reset.

// File: rtl/nau_pkg.sv
package nau_pkg;

    localparam int NDIR = 4;

    typedef enum logic [2:0] {
        DIR_NONE = 3'd0,
        DIR_W    = 3'd1,
        DIR_N    = 3'd2,
        DIR_E    = 3'd3,
        DIR_S    = 3'd4
    } dir_e;

    localparam logic [2:0] STAT_DONE_Q2 = 3'd5;

    typedef struct packed {
        dir_e       min_dir;
        logic [3:0] eq;
        logic       plat;
        logic       inner;
        dir_e       arrow;
    } flags_t;

    function automatic dir_e dir_of_slot(input logic [1:0] slot);
        return dir_e'({1'b0, slot} + 3'd1);
    endfunction

endpackage

// File: rtl/nau_min_tree.sv
module nau_min_tree
    import nau_pkg::*;
#(
    parameter int PW = 8
) (
    input  logic [NDIR-1:0][PW:0] key,
    output logic [PW:0]           min_key,
    output dir_e                  min_dir
);
    logic          le_a, le_b, le_c;
    logic [PW:0]   win_a, win_b;

    // first level: W against N, E against S; ties keep the earlier slot
    assign le_a  = key[0] <= key[1];
    assign le_b  = key[2] <= key[3];
    assign win_a = le_a ? key[0] : key[1];
    assign win_b = le_b ? key[2] : key[3];

    // second level: the two winners
    assign le_c    = win_a <= win_b;
    assign min_key = le_c ? win_a : win_b;

    always_comb begin
        unique case ({le_c, le_a, le_b})
            3'b110, 3'b111: min_dir = DIR_W;
            3'b100, 3'b101: min_dir = DIR_N;
            3'b001, 3'b011: min_dir = DIR_E;
            default:        min_dir = DIR_S;
        endcase
        // top key bit marks an invalid (infinite) entry
        if (min_key[PW]) min_dir = DIR_NONE;
    end
endmodule

// File: rtl/nau_plateau.sv
module nau_plateau
    import nau_pkg::*;
#(
    parameter int PW = 8
) (
    input  logic                  scan_mode,
    input  logic [PW:0]           ctr_key,
    input  logic [NDIR-1:0][PW:0] key,
    output logic [NDIR-1:0]       eq,
    output logic                  plat,
    output logic                  inner
);
    logic [NDIR-1:0] not_above;

    for (genvar i = 0; i < NDIR; i++) begin : g_cmp
        assign eq[i]        = (key[i] == ctr_key);
        assign not_above[i] = (ctr_key <= key[i]);
    end

    assign plat  = scan_mode && (|eq);
    assign inner = !scan_mode && (&not_above);
endmodule

// File: rtl/nau_arrow.sv
module nau_arrow
    import nau_pkg::*;
#(
    parameter int SW = 3
) (
    input  logic                  inner,
    input  logic                  lower,
    input  dir_e                  min_dir,
    input  logic [NDIR-1:0]       eq,
    input  logic [NDIR-1:0][SW-1:0] stat,
    output dir_e                  arrow
);
    localparam logic [SW-1:0] DONE = SW'(STAT_DONE_Q2);

    dir_e inner_pick;

    always_comb begin
        inner_pick = DIR_NONE;
        // scan from the lowest priority so the earliest slot wins
        for (int i = NDIR - 1; i >= 0; i--) begin
            if (eq[i] && stat[i] == DONE) inner_pick = dir_of_slot(2'(i));
        end
    end

    always_comb begin
        if (inner)      arrow = inner_pick;
        else if (lower) arrow = min_dir;
        else            arrow = DIR_NONE;
    end
endmodule

// File: rtl/nbr_arrow_unit.sv
module nbr_arrow_unit
    import nau_pkg::*;
#(
    parameter int PW      = 8,
    parameter int SW      = 3,
    parameter bit REG_OUT = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               scan_mode,
    input  logic [PW-1:0]      ctr_val,
    input  logic [4*PW-1:0]    nbr_val,
    input  logic [3:0]         nbr_ok,
    input  logic [4*SW-1:0]    nbr_stat,
    output logic [PW-1:0]      min_val,
    output logic [2:0]         min_dir,
    output logic [3:0]         eq_flags,
    output logic               plat_flag,
    output logic               inner_flag,
    output logic [2:0]         arrow_code
);
    localparam logic [PW:0] INF_KEY = '1;

    logic [NDIR-1:0][PW:0]   key;
    logic [NDIR-1:0][SW-1:0] stat;
    logic [PW:0]             ctr_key;
    logic [PW:0]             min_key;
    logic                    lower;
    flags_t                  nxt;
    logic [PW-1:0]           nxt_min_val;

    assign ctr_key = {1'b0, ctr_val};

    for (genvar i = 0; i < NDIR; i++) begin : g_slot
        assign key[i]  = nbr_ok[i] ? {1'b0, nbr_val[i*PW +: PW]} : INF_KEY;
        assign stat[i] = nbr_stat[i*SW +: SW];
    end

    nau_min_tree #(.PW(PW)) u_tree (
        .key     (key),
        .min_key (min_key),
        .min_dir (nxt.min_dir)
    );

    nau_plateau #(.PW(PW)) u_plat (
        .scan_mode (scan_mode),
        .ctr_key   (ctr_key),
        .key       (key),
        .eq        (nxt.eq),
        .plat      (nxt.plat),
        .inner     (nxt.inner)
    );

    assign lower       = (min_key < ctr_key);
    assign nxt_min_val = min_key[PW-1:0];

    nau_arrow #(.SW(SW)) u_arrow (
        .inner   (nxt.inner),
        .lower   (lower),
        .min_dir (nxt.min_dir),
        .eq      (nxt.eq),
        .stat    (stat),
        .arrow   (nxt.arrow)
    );

    flags_t        out_f;
    logic [PW-1:0] out_min;

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                out_f   <= '0;
                out_min <= '0;
            end else begin
                out_f   <= nxt;
                out_min <= nxt_min_val;
            end
        end
    end else begin : g_comb
        assign out_f   = nxt;
        assign out_min = nxt_min_val;
    end

    assign min_val    = out_min;
    assign min_dir    = out_f.min_dir;
    assign eq_flags   = out_f.eq;
    assign plat_flag  = out_f.plat;
    assign inner_flag = out_f.inner;
    assign arrow_code = out_f.arrow;
endmodule

// File: rtl/nau_chk.sv
module nau_chk
    import nau_pkg::*;
#(
    parameter int PW = 8
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  scan_mode,
    input logic [3:0]            nbr_ok,
    input logic [NDIR-1:0][PW:0] key,
    input logic [PW:0]           min_key,
    input flags_t                nxt
);
    assert_plat_scan_only_R5: assert property (@(posedge clk) disable iff (rst)
        nxt.plat |-> scan_mode);

    assert_inner_queue_only_R6: assert property (@(posedge clk) disable iff (rst)
        nxt.inner |-> !scan_mode);

    assert_invalid_never_equal_R9: assert property (@(posedge clk) disable iff (rst)
        (nxt.eq & ~nbr_ok) == 4'b0000);

    assert_min_is_lowest_R1: assert property (@(posedge clk) disable iff (rst)
        (min_key <= key[0]) && (min_key <= key[1]) &&
        (min_key <= key[2]) && (min_key <= key[3]));

    assert_inner_arrow_equal_R8: assert property (@(posedge clk) disable iff (rst)
        nxt.inner |->
            (nxt.arrow == DIR_NONE) ||
            (nxt.arrow == DIR_W && nxt.eq[0]) || (nxt.arrow == DIR_N && nxt.eq[1]) ||
            (nxt.arrow == DIR_E && nxt.eq[2]) || (nxt.arrow == DIR_S && nxt.eq[3]));

    assert_no_dir_when_empty_R2: assert property (@(posedge clk) disable iff (rst)
        (nbr_ok == 4'b0000) |-> (nxt.min_dir == DIR_NONE));
endmodule

bind nbr_arrow_unit nau_chk #(.PW(PW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .scan_mode (scan_mode),
    .nbr_ok    (nbr_ok),
    .key       (key),
    .min_key   (min_key),
    .nxt       (nxt)
);

// File: tb/sim_nbr_arrow_unit.sv
`timescale 1ns/1ps
module sim_nbr_arrow_unit;
    localparam int PW = 8;
    localparam int SW = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          scan_mode = 1'b0;
    logic [PW-1:0] ctr_val = '0;
    logic [4*PW-1:0] nbr_val = '0;
    logic [3:0]    nbr_ok = '0;
    logic [4*SW-1:0] nbr_stat = '0;
    logic [PW-1:0] min_val;
    logic [2:0]    min_dir;
    logic [3:0]    eq_flags;
    logic          plat_flag, inner_flag;
    logic [2:0]    arrow_code;

    int n_cmp = 0;
    int n_bad = 0;

    int nv[4];
    int ns[4];
    logic [3:0] ok_in;
    int c_in;
    logic sm_in;

    int e_min, e_dir, e_eq, e_plat, e_inner, e_arrow;

    always #2 clk = ~clk;

    nbr_arrow_unit #(.PW(PW), .SW(SW), .REG_OUT(1'b1)) u0 (
        .clk(clk), .rst(rst), .scan_mode(scan_mode), .ctr_val(ctr_val),
        .nbr_val(nbr_val), .nbr_ok(nbr_ok), .nbr_stat(nbr_stat),
        .min_val(min_val), .min_dir(min_dir), .eq_flags(eq_flags),
        .plat_flag(plat_flag), .inner_flag(inner_flag), .arrow_code(arrow_code)
    );

    task automatic check(input string req, input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, tag, act, exp);
        end
    endtask

    // behavioural reference: linear scan, strict less keeps the earliest
    task automatic model();
        int best = -1;
        int bestv = 1 << PW;
        int allge = 1;
        e_eq = 0;
        for (int i = 0; i < 4; i++) begin
            if (ok_in[i]) begin
                if (nv[i] < bestv) begin best = i; bestv = nv[i]; end
                if (nv[i] == c_in) e_eq |= (1 << i);
                if (c_in > nv[i]) allge = 0;
            end
        end
        e_dir   = best + 1;
        e_min   = (best < 0) ? (1 << PW) - 1 : bestv;
        e_plat  = (sm_in && e_eq != 0) ? 1 : 0;
        e_inner = (!sm_in && allge == 1) ? 1 : 0;
        e_arrow = 0;
        if (e_inner == 1) begin
            for (int i = 3; i >= 0; i--)
                if (((e_eq >> i) & 1) == 1 && ns[i] == 5) e_arrow = i + 1;
        end else if (best >= 0 && bestv < c_in) begin
            e_arrow = best + 1;
        end
    endtask

    task automatic apply(input string tag);
        @(negedge clk);
        scan_mode = sm_in;
        ctr_val   = PW'(c_in);
        nbr_ok    = ok_in;
        for (int i = 0; i < 4; i++) begin
            nbr_val[i*PW +: PW] = PW'(nv[i]);
            nbr_stat[i*SW +: SW] = SW'(ns[i]);
        end
        model();
        @(negedge clk);
        check("R1",    tag, int'(min_val),    e_min);
        check("R2 R3", tag, int'(min_dir),    e_dir);
        check("R4",    tag, int'(eq_flags),   e_eq);
        check("R5",    tag, int'(plat_flag),  e_plat);
        check("R6",    tag, int'(inner_flag), e_inner);
        check("R7 R8", tag, int'(arrow_code), e_arrow);
    endtask

    task automatic setv(input int c, input int w, input int n, input int e, input int s,
                        input logic [3:0] ok, input logic sm);
        c_in = c; nv[0] = w; nv[1] = n; nv[2] = e; nv[3] = s;
        ok_in = ok; sm_in = sm;
        for (int i = 0; i < 4; i++) ns[i] = 0;
    endtask

    initial begin
        #(4 * 100000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R10: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R10", "reset min_val", int'(min_val), 0);
        check("R10", "reset min_dir", int'(min_dir), 0);
        check("R10", "reset arrow", int'(arrow_code), 0);
        check("R10", "reset flags", int'({eq_flags, plat_flag, inner_flag}), 0);
        rst = 1'b0;

        setv(50, 40, 10, 30, 20, 4'hF, 1'b1); apply("R1 R7 lowest north");
        setv(50, 10, 10, 30, 20, 4'hF, 1'b1); apply("R3 tie W N");
        setv(50, 30, 30, 12, 12, 4'hF, 1'b0); apply("R3 tie E S");
        setv(50, 12, 30, 12, 12, 4'hF, 1'b0); apply("R3 tie W E S");
        setv(7, 1, 2, 3, 4, 4'h0, 1'b0);      apply("R2 R9 none valid queue");
        setv(7, 1, 2, 3, 4, 4'h0, 1'b1);      apply("R2 R9 none valid scan");
        setv(20, 30, 20, 40, 25, 4'hF, 1'b1); apply("R4 R5 plateau scan");
        setv(20, 20, 30, 40, 25, 4'b1110, 1'b1); apply("R9 invalid equal W");
        setv(20, 5, 30, 40, 25, 4'b1110, 1'b0);  apply("R9 invalid low W");
        setv(20, 20, 20, 30, 20, 4'hF, 1'b0); ns[1] = 5; ns[3] = 5;
        apply("R8 inner pick N over S");
        setv(20, 20, 20, 30, 20, 4'hF, 1'b0); ns[0] = 6; ns[3] = 5;
        apply("R8 inner pick S");
        setv(20, 20, 20, 30, 20, 4'hF, 1'b0); ns[0] = 3; ns[1] = 4; ns[2] = 5;
        apply("R8 inner none labelled");
        setv(20, 30, 25, 20, 40, 4'b1011, 1'b0); ns[2] = 5;
        apply("R9 invalid labelled E");
        setv(3, 9, 8, 7, 6, 4'hF, 1'b1);      apply("R7 minimum scan");
        setv(20, 30, 15, 20, 18, 4'hF, 1'b0); apply("R6 R7 non-inner queue");
        setv(20, 20, 20, 20, 20, 4'hF, 1'b1); ns[0] = 5; apply("R5 R8 flat scan");

        for (int k = 0; k < 4000; k++) begin
            c_in  = int'($urandom_range(0, 3));
            ok_in = 4'($urandom_range(0, 15));
            sm_in = 1'($urandom_range(0, 1));
            for (int i = 0; i < 4; i++) begin
                nv[i] = (k % 7 == 0) ? int'($urandom_range(0, 255)) : int'($urandom_range(0, 3));
                ns[i] = int'($urandom_range(0, 6));
            end
            if (k % 5 == 0) ok_in = 4'hF;
            apply("R9 R10 random");
        end

        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R10", "reset again arrow", int'(arrow_code), 0);
        check("R10", "reset again min_val", int'(min_val), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule